// File: doc/BRIEF.md
# SHA-1 Block Hashing Engine with Register Access

This block computes the SHA-1 compression function over one 512-bit message block at a time. A bus master reaches it through a small register window. The master first loads the block as sixteen 32-bit words. It then sets a command bit that either starts a new message from the standard initial chaining values or continues from the digest left by the previous block. It polls status until the engine reports completion, and finally reads the 160-bit digest as five words. Message padding and length encoding are the job of software.

The engine is iterative and runs one round per clock. It keeps a sliding sixteen-word schedule window rather than all eighty expanded words. A command is taken when its bit changes from 0 to 1, because software sets a bit and then clears it. A bit that stays set does nothing more. A rising command bit that arrives while a hash is running is dropped. The register window is plain memory-mapped access with no stream interface, so there are no valid/ready handshakes and no back-pressure. Every access completes in the cycle in which chip select is high.

Top module: `sha1_accel`

## Requirements
- R1: After reset, the status register (0x09) reads 0x1 (bit 0 ready set, bit 1 digest-valid clear), and every digest word reads 0.
- R2: Address 0x00 reads 0x68736831 and 0x01 reads 0x636f7265 (the eight ASCII characters "hsh1core", first character in the most significant byte). Address 0x02 reads 0x312e3030 ("1.00").
- R3: Block words are written and read back at 0x10..0x1F, where 0x10 holds block bits 511:480 and 0x1F holds bits 31:0. Digest words are read at 0x20..0x24, where 0x20 holds digest bits 159:128.
- R4: A 0-to-1 change of control bit 0 (0x08) hashes the loaded block from the standard initial values. The padded one-block message "abc" gives a9993e364706816aba3e25717850c26c9cd0d89d.
- R5: A 0-to-1 change of control bit 1 hashes the loaded block, chaining on the current digest. For the 56-character two-block message, the init block gives f4286818c37b27ae0408f581846771484a566572 and the following next block gives 84983e441c3bd26ebaae4aa1f95129e5e54670f1.
- R6: Commands act on the rising edge of a control bit only. A bit left at 1 after a hash completes starts no further hash, and status stays 0x3.
- R7: When a command is accepted, both ready and valid drop in the next cycle, so status reads 0. Both return to 1 together after the 80 rounds and the digest update, no more than 81 cycles after acceptance.
- R8: Reads of unmapped addresses (for example 0x03, 0x0A, 0x25, 0xFF) return 0.
- R9: Writes to the identification, status and digest addresses are ignored. Those addresses read back their previous values.
- R10: A rising command bit that arrives while a hash is running is ignored. The running hash finishes with the digest of the original command, and no second hash follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select; an access happens while high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr; 0 when not reading |

## Verification
The assertions check four properties on every cycle: that accepting a command clears ready and valid in the next cycle, that valid never shows while the engine is busy, that a busy period never runs past 81 cycles, and that each command pulse lasts a single cycle, so a held bit cannot retrigger. Whether the hash arithmetic is correct, how words are ordered in the register window, and how digests chain across blocks only show up in the bench's scenarios. That is why the bench compares the digests of known messages, and also covers held and mid-hash command bits, read-only writes and unmapped reads.

// File: rtl/sha1_accel_pkg.sv
package sha1_accel_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 16;
  localparam int DIG_WORDS = 5;
  localparam int ROUNDS    = 80;
  localparam int STAGE_LEN = 20;
  localparam int RND_W     = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD} core_state_e;

  // index 0 is the most significant chaining word
  localparam logic [DIG_WORDS-1:0][WORD_W-1:0] CHAIN_IV =
    {32'hC3D2E1F0, 32'h10325476, 32'h98BADCFE, 32'hEFCDAB89, 32'h67452301};

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t mix_fn(input logic [1:0] stage, input word_t b,
                                   input word_t c, input word_t d);
    case (stage)
      2'd0:    return (b & c) | (~b & d);
      2'd2:    return (b & c) | (b & d) | (c & d);
      default: return b ^ c ^ d;
    endcase
  endfunction

  function automatic word_t stage_k(input logic [1:0] stage);
    case (stage)
      2'd0:    return 32'h5A827999;
      2'd1:    return 32'h6ED9EBA1;
      2'd2:    return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction
endpackage

// File: rtl/sha1_msg_window.sv
module sha1_msg_window
  import sha1_accel_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic                               shift,
  input  logic [BLK_WORDS-1:0][WORD_W-1:0]   blk,
  output word_t                              cur
);
  word_t win_q [BLK_WORDS];
  word_t fresh;

  assign fresh = rotl(win_q[13] ^ win_q[8] ^ win_q[2] ^ win_q[0], 1);
  assign cur   = win_q[0];

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     win_q[i] <= '0;
      else if (load)  win_q[i] <= blk[i];
      else if (shift) begin
        if (i == BLK_WORDS - 1) win_q[i] <= fresh;
        else                    win_q[i] <= win_q[(i + 1) % BLK_WORDS];
      end
    end
  end

  AST_LOAD_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(blk[0])); // R3
endmodule

// File: rtl/sha1_round_core.sv
module sha1_round_core
  import sha1_accel_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               go_init,
  input  logic                               go_next,
  input  word_t                              msg_word,
  output logic                               ready,
  output logic                               valid,
  output logic                               win_load,
  output logic                               win_shift,
  output logic [DIG_WORDS-1:0][WORD_W-1:0]   digest
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  core_state_e                       state_q;
  logic [RND_W-1:0]                  rnd_q;
  logic                              valid_q;
  logic [DIG_WORDS-1:0][WORD_W-1:0]  h_q, v_q, v_nx;
  logic [1:0]                        stage;
  logic                              accept;
  word_t                             t_sum;

  assign ready     = (state_q == ST_IDLE);
  assign valid     = valid_q;
  assign accept    = ready && (go_init || go_next);
  assign win_load  = accept;
  assign win_shift = (state_q == ST_RUN);
  assign digest    = h_q;

  always_comb begin
    if (rnd_q < RND_W'(STAGE_LEN))          stage = 2'd0;
    else if (rnd_q < RND_W'(2 * STAGE_LEN)) stage = 2'd1;
    else if (rnd_q < RND_W'(3 * STAGE_LEN)) stage = 2'd2;
    else                                    stage = 2'd3;
    t_sum   = rotl(v_q[0], 5) + mix_fn(stage, v_q[1], v_q[2], v_q[3])
            + v_q[4] + stage_k(stage) + msg_word;
    v_nx[0] = t_sum;
    v_nx[1] = v_q[0];
    v_nx[2] = rotl(v_q[1], 30);
    v_nx[3] = v_q[2];
    v_nx[4] = v_q[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
      valid_q <= 1'b0;
      h_q     <= '0;
      v_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          if (go_init) begin
            h_q <= CHAIN_IV;
            v_q <= CHAIN_IV;
          end else begin
            v_q <= h_q;
          end
          rnd_q   <= '0;
          valid_q <= 1'b0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          v_q <= v_nx;
          if (rnd_q == LAST_RND) state_q <= ST_FOLD;
          else                   rnd_q   <= rnd_q + 1'b1;
        end
        default: begin
          for (int i = 0; i < DIG_WORDS; i++) h_q[i] <= h_q[i] + v_q[i];
          valid_q <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  logic [RND_W:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (ready)  busy_cnt <= '0;
    else             busy_cnt <= busy_cnt + 1'b1;
  end

  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready && !valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ready); // R7
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= (RND_W+1)'(ROUNDS + 1)); // R7
  AST_RUN_KEEPS_DIGEST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) && (go_init || go_next) |=> $stable(h_q)); // R10
endmodule

// File: rtl/sha1_accel.sv
module sha1_accel
  import sha1_accel_pkg::*;
#(
  parameter logic [31:0] ID_HI   = 32'h68736831,
  parameter logic [31:0] ID_LO   = 32'h636f7265,
  parameter logic [31:0] ID_VER  = 32'h312e3030
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam logic [7:0] A_ID_HI  = 8'h00;
  localparam logic [7:0] A_ID_LO  = 8'h01;
  localparam logic [7:0] A_VER    = 8'h02;
  localparam logic [7:0] A_CMD    = 8'h08;
  localparam logic [7:0] A_STAT   = 8'h09;
  localparam logic [3:0] BLK_PAGE = 4'h1;
  localparam logic [4:0] DIG_PAGE = 5'b00100;

  logic [BLK_WORDS-1:0][WORD_W-1:0] blk_q;
  logic [DIG_WORDS-1:0][WORD_W-1:0] digest;
  logic [1:0] cmd_q, cmd_prev_q;
  logic       go_init, go_next, ready, valid, win_load, win_shift;
  word_t      msg_word;
  logic       wr_hit, rd_hit;

  assign wr_hit = sel && wr;
  assign rd_hit = sel && !wr;

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blk_q[i] <= '0;
      else if (wr_hit && addr == {BLK_PAGE, 4'(i)}) blk_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      cmd_prev_q <= '0;
    end else begin
      if (wr_hit && addr == A_CMD) cmd_q <= wdata[1:0];
      cmd_prev_q <= cmd_q;
    end
  end

  // init wins if both bits rise together
  assign go_init = cmd_q[0] && !cmd_prev_q[0];
  assign go_next = cmd_q[1] && !cmd_prev_q[1] && !go_init;

  sha1_msg_window i_window (
    .clk(clk), .rst_n(rst_n), .load(win_load), .shift(win_shift),
    .blk(blk_q), .cur(msg_word)
  );

  sha1_round_core i_core (
    .clk(clk), .rst_n(rst_n), .go_init(go_init), .go_next(go_next),
    .msg_word(msg_word), .ready(ready), .valid(valid),
    .win_load(win_load), .win_shift(win_shift), .digest(digest)
  );

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      if (addr == A_ID_HI)                    rdata = ID_HI;
      else if (addr == A_ID_LO)               rdata = ID_LO;
      else if (addr == A_VER)                 rdata = ID_VER;
      else if (addr == A_CMD)                 rdata = {30'd0, cmd_q};
      else if (addr == A_STAT)                rdata = {30'd0, valid, ready};
      else if (addr[7:4] == BLK_PAGE)         rdata = blk_q[addr[3:0]];
      else if (addr[7:3] == DIG_PAGE && addr[2:0] < 3'(DIG_WORDS))
                                              rdata = digest[addr[2:0]];
    end
  end

  AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    go_init |=> !go_init); // R6
  AST_NEXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    go_next |=> !go_next); // R6
endmodule

// File: tb/test_sha1_accel.sv
`timescale 1ns/1ps
module test_sha1_accel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { string tag; logic [159:0] dig; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  sha1_accel i_sha1_accel (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic load_block(input logic [511:0] b);
    for (int i = 0; i < 16; i++) bus_wr(8'h10 + 8'(i), b[511 - 32*i -: 32]);
  endtask

  task automatic read_digest(output logic [159:0] dg);
    logic [31:0] w;
    for (int i = 0; i < 5; i++) begin
      bus_rd(8'h20 + 8'(i), w);
      dg[159 - 32*i -: 32] = w;
    end
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    int tries;
    s = 0; tries = 0;
    while (s == 0 && tries < 200) begin
      bus_rd(8'h09, s);
      tries++;
    end
    chk(req, {128'd0, s}, 160'h3);
  endtask

  // driver: loads a block, pushes the expected digest, issues the command
  task automatic drive_block(input logic [511:0] b, input logic [31:0] cmd,
                             input bit clear, input string tag, input logic [159:0] dg);
    exp_t e;
    e.tag = tag; e.dig = dg;
    exp_q.push_back(e);
    load_block(b);
    bus_wr(8'h08, cmd);
    if (clear) bus_wr(8'h08, 32'h0);
  endtask

  // monitor: waits for completion, pops the oldest expectation and compares
  task automatic monitor_pop();
    exp_t e;
    logic [159:0] got;
    e = exp_q.pop_front();
    wait_done(e.tag);
    read_digest(got);
    chk(e.tag, got, e.dig);
  endtask

  localparam logic [511:0] BLK_ABC = {32'h61626380, {14{32'h0}}, 32'h00000018};
  localparam logic [511:0] BLK_TWO_A = {
    32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
    32'h65666768, 32'h66676869, 32'h6768696A, 32'h68696A6B,
    32'h696A6B6C, 32'h6A6B6C6D, 32'h6B6C6D6E, 32'h6C6D6E6F,
    32'h6D6E6F70, 32'h6E6F7071, 32'h80000000, 32'h00000000};
  localparam logic [511:0] BLK_TWO_B = {{15{32'h0}}, 32'h000001C0};
  localparam logic [159:0] DG_ABC   = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;
  localparam logic [159:0] DG_TWO_A = 160'hf4286818c37b27ae0408f581846771484a566572;
  localparam logic [159:0] DG_TWO_B = 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1;

  initial begin
    logic [31:0]  r;
    logic [159:0] dg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_rd(8'h09, r);  chk("R1 status", {128'd0, r}, 160'h1);
    read_digest(dg);   chk("R1 digest", dg, 160'h0);

    bus_rd(8'h00, r);  chk("R2 id0", {128'd0, r}, 160'h68736831);
    bus_rd(8'h01, r);  chk("R2 id1", {128'd0, r}, 160'h636f7265);
    bus_rd(8'h02, r);  chk("R2 ver", {128'd0, r}, 160'h312e3030);

    bus_wr(8'h00, 32'hDEADBEEF); bus_rd(8'h00, r); chk("R9 id0", {128'd0, r}, 160'h68736831);
    bus_wr(8'h09, 32'hFFFFFFFF); bus_rd(8'h09, r); chk("R9 status", {128'd0, r}, 160'h1);
    bus_wr(8'h22, 32'h12345678); bus_rd(8'h22, r); chk("R9 digest", {128'd0, r}, 160'h0);

    bus_rd(8'h03, r); chk("R8 0x03", {128'd0, r}, 160'h0);
    bus_rd(8'h0A, r); chk("R8 0x0A", {128'd0, r}, 160'h0);
    bus_rd(8'h25, r); chk("R8 0x25", {128'd0, r}, 160'h0);
    bus_rd(8'hFF, r); chk("R8 0xFF", {128'd0, r}, 160'h0);

    // R4 and R7: abc, status sampled right after the command
    drive_block(BLK_ABC, 32'h1, 1'b1, "R4 abc", DG_ABC);
    bus_rd(8'h09, r);  chk("R7 busy status", {128'd0, r}, 160'h0);
    bus_rd(8'h10, r);  chk("R3 word 0x10", {128'd0, r}, 160'h61626380);
    bus_rd(8'h1F, r);  chk("R3 word 0x1F", {128'd0, r}, 160'h18);
    monitor_pop();

    // R6: bit left high, no second hash
    drive_block(BLK_TWO_A, 32'h1, 1'b0, "R6 held init", DG_TWO_A);
    monitor_pop();
    repeat (20) @(negedge clk);
    bus_rd(8'h09, r);  chk("R6 no retrigger", {128'd0, r}, 160'h3);
    bus_wr(8'h08, 32'h1);
    bus_rd(8'h09, r);  chk("R6 rewrite same level", {128'd0, r}, 160'h3);
    read_digest(dg);   chk("R6 digest kept", dg, DG_TWO_A);
    bus_wr(8'h08, 32'h0);

    // R5: init then next chaining
    drive_block(BLK_TWO_A, 32'h1, 1'b1, "R5 first", DG_TWO_A);
    monitor_pop();
    drive_block(BLK_TWO_B, 32'h2, 1'b1, "R5 second", DG_TWO_B);
    monitor_pop();

    // R10: fresh edges during busy are ignored
    drive_block(BLK_ABC, 32'h1, 1'b1, "R10 abc", DG_ABC);
    bus_wr(8'h08, 32'h1);
    bus_wr(8'h08, 32'h2);
    bus_rd(8'h09, r);  chk("R10 still busy", {128'd0, r}, 160'h0);
    monitor_pop();
    repeat (10) @(negedge clk);
    bus_rd(8'h09, r);  chk("R10 no late hash", {128'd0, r}, 160'h3);
    read_digest(dg);   chk("R10 digest", dg, DG_ABC);
    bus_wr(8'h08, 32'h0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule